// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Decoder

This block takes one 32-bit instruction word aimed at a single-precision floating-point coprocessor and turns it into a class, an operation code and a set of register indices. Bits are numbered with bit 0 as the most significant bit of the word, so nibble k covers bits 4k..4k+3. Bit 0 therefore sits at the top of the `instr` bus and bit 31 at position 0.

The block first checks the two fixed marker nibbles. It then sorts the word into one of six classes: binary arithmetic, unary arithmetic, conversion, compare, moves between core and FP registers, or moves between core and control registers. Each FP register index is five bits wide. Its top bit comes from the last nibble of the word and its low four bits come from a separate nibble. A word that fits no pattern is flagged illegal and decodes as a no-op.

The decode logic is purely combinational. A parameter adds an output register, which is on by default.

Top module: `fpcop_decoder`

## Requirements
- R1: A word is legal only if bits 0..3 equal 0xF and bits 12..15 equal 0x7. Any other word raises `illegal`.
- R2: When `illegal` is 1, `cls` and `op` are 0 (no-op), and `frd`, `frn`, `frm`, `core_idx`, `ctl_idx`, `cond` and `may_trap` are all 0.
- R3: For a legal word, the index outputs are built as follows:
  - `frd` = {bit 28, bits 4..7}
  - `frn` = {bit 29, bits 20..23}
  - `frm` = {bit 30, bits 24..27}
  - `core_idx` = bits 8..11
  - `ctl_idx` = bits 4..7
- R4: Binary arithmetic decodes to class 1. It requires bits 16..19 = 0, bit 31 = 0 and bits 8..11 in the range 0..3. Those values map to op 1 add, 2 subtract, 3 multiply and 4 divide.
- R5: Unary arithmetic decodes to class 2. It requires bits 16..19 = 0, bits 24..27 = 0, bit 30 = 0, bit 31 = 0 and bits 8..11 in the range 4..7. Those values map to op 5 square root, 6 absolute value, 7 move and 8 negate. A nonzero required-zero field makes the word illegal.
- R6: Conversion decodes to class 3, with the same zero fields as R5. The patterns are:
  - bits 16..19 = 0 with bits 8..11 = 0xC, 0xD, 0xE or 0xF gives op 9 (round to nearest), 10 (truncate), 11 (ceiling) or 12 (floor).
  - bits 16..19 = 1 with bits 8..11 = 4 gives op 13 (default float-to-int).
  - bits 16..19 = 9 with bits 8..11 = 0 gives op 14 (int-to-float).
  - Any other value of bits 8..11 under bits 16..19 = 1 or 9 is illegal.
- R7: A compare requires bits 16..19 = 2, bits 4..7 = 0, bit 28 = 0 and bit 31 = 0. It decodes to class 4 and op 15, and `cond` carries bits 8..11. For every other class, `cond` is 0.
- R8: An FP register move requires bits 16..19 = 0xF, bits 20..27 = 0, bit 29 = 0 and bit 30 = 0. It decodes to class 5. Bit 31 = 0 gives op 16 (core to coprocessor) and bit 31 = 1 gives op 17 (coprocessor to core).
- R9: A control register move requires bits 16..19 = 0xF, bits 20..27 = 0, bit 28 = 0, bit 29 = 0 and bit 30 = 1. It decodes to class 6. Bit 31 = 0 gives op 18 and bit 31 = 1 gives op 19.
- R10: `may_trap` is 1 exactly for legal words of classes 1 to 4 and is 0 for the move classes.
- R11: With the default `REG_OUT` = 1, every output shows the decode of the word sampled at the previous rising clock edge. A synchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word; bit 0 of the word is instr[31] |
| cls | output | 3 | Instruction class (0 no-op, 1..6 as in R4 to R9) |
| op | output | 5 | Operation code |
| frd | output | 5 | Destination FP register index |
| frn | output | 5 | First source FP register index |
| frm | output | 5 | Second source FP register index |
| core_idx | output | 4 | Core register index |
| ctl_idx | output | 4 | Control register index |
| cond | output | 4 | Compare condition code |
| illegal | output | 1 | Word matched no defined pattern |
| may_trap | output | 1 | Instruction class can raise an exception |

## Verification
The only state in this block is the output register. If that register holds a wrong value, the effect appears one cycle after the offending word is presented. Typical symptoms are a class that disagrees with its opcode range, an illegal word whose index fields leak through, or a move that claims it can trap. The checker flags each of these on the same edge that shows it. The scoreboard compares every output field one cycle after each word is driven. It exercises each class boundary and each required-zero field with a single bit flipped.

// File: rtl/fpcop_pkg.sv
package fpcop_pkg;
    localparam int INSTR_W = 32;
    localparam int NIB_W   = 4;
    localparam int NIB_N   = INSTR_W / NIB_W;
    localparam int FR_W    = NIB_W + 1;
    localparam int CLS_W   = 3;
    localparam int OP_W    = 5;

    typedef enum logic [CLS_W-1:0] {
        CL_NOP = 3'd0, CL_BIN = 3'd1, CL_UNA = 3'd2, CL_CVT = 3'd3,
        CL_CMP = 3'd4, CL_MVF = 3'd5, CL_MVC = 3'd6
    } cls_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_MUL = 5'd3,
        OP_DIV = 5'd4,  OP_SQRT = 5'd5, OP_ABS = 5'd6,  OP_MOV = 5'd7,
        OP_NEG = 5'd8,  OP_CVRN = 5'd9, OP_CVTZ = 5'd10, OP_CVUP = 5'd11,
        OP_CVDN = 5'd12, OP_CVDF = 5'd13, OP_I2F = 5'd14, OP_CMP = 5'd15,
        OP_C2F = 5'd16, OP_F2C = 5'd17, OP_C2X = 5'd18, OP_X2C = 5'd19
    } op_e;

    // Word split into nibbles, nibble 0 holds bits 0..3 (the top of the bus)
    typedef struct packed {
        logic [NIB_N-1:0][NIB_W-1:0] nib;
    } fields_t;

    typedef struct packed {
        cls_e              cls;
        op_e               op;
        logic [FR_W-1:0]   frd;
        logic [FR_W-1:0]   frn;
        logic [FR_W-1:0]   frm;
        logic [NIB_W-1:0]  core_idx;
        logic [NIB_W-1:0]  ctl_idx;
        logic [NIB_W-1:0]  cond;
        logic              illegal;
        logic              may_trap;
    } dec_t;
endpackage

// File: rtl/fpcop_fields.sv
// Splits the instruction word into nibbles numbered from the MSB end.
// Assumes bit 0 of the word is instr[INSTR_W-1].
module fpcop_fields
    import fpcop_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            flds
);
    // One slice per nibble, nibble k taken from the MSB side
    for (genvar k = 0; k < NIB_N; k++) begin : g_nib
        assign flds.nib[k] = instr[INSTR_W-1-NIB_W*k -: NIB_W];
    end
endmodule

// File: rtl/fpcop_classify.sv
// Matches the nibble fields against every defined pattern and builds the
// decoded record. Purely combinational; unmatched words become a no-op
// with the illegal flag set and every index cleared.
module fpcop_classify
    import fpcop_pkg::*;
(
    input  fields_t flds,
    output dec_t    dec
);
    logic [NIB_W-1:0] n1, n2, n4, n5, n6, n7;
    logic             hdr_ok, b28, b29, b30, b31;
    cls_e             cls;
    op_e              op;

    assign n1  = flds.nib[1];
    assign n2  = flds.nib[2];
    assign n4  = flds.nib[4];
    assign n5  = flds.nib[5];
    assign n6  = flds.nib[6];
    assign n7  = flds.nib[7];
    assign b28 = n7[3];
    assign b29 = n7[2];
    assign b30 = n7[1];
    assign b31 = n7[0];
    assign hdr_ok = (flds.nib[0] == 4'hF) && (flds.nib[3] == 4'h7);

    // Pick class and operation from the sub-opcode nibble and zero fields
    always_comb begin
        cls = CL_NOP;
        op  = OP_NOP;
        if (hdr_ok) begin
            case (n4)
                4'h0: if (!b31) begin
                    if (n2 <= 4'h3) begin
                        cls = CL_BIN;
                        op  = op_e'(OP_W'(n2) + OP_W'(1));
                    end else if (n6 == '0 && !b30) begin
                        if (n2 <= 4'h7) begin
                            cls = CL_UNA;
                            op  = op_e'(OP_W'(n2) + OP_W'(1));
                        end else if (n2 >= 4'hC) begin
                            cls = CL_CVT;
                            op  = op_e'(OP_W'(n2) - OP_W'(3));
                        end
                    end
                end
                4'h1: if (n2 == 4'h4 && n6 == '0 && !b30 && !b31) begin
                    cls = CL_CVT;
                    op  = OP_CVDF;
                end
                4'h9: if (n2 == 4'h0 && n6 == '0 && !b30 && !b31) begin
                    cls = CL_CVT;
                    op  = OP_I2F;
                end
                4'h2: if (n1 == '0 && !b28 && !b31) begin
                    cls = CL_CMP;
                    op  = OP_CMP;
                end
                4'hF: if (n5 == '0 && n6 == '0 && !b29) begin
                    if (!b30) begin
                        cls = CL_MVF;
                        op  = b31 ? OP_F2C : OP_C2F;
                    end else if (!b28) begin
                        cls = CL_MVC;
                        op  = b31 ? OP_X2C : OP_C2X;
                    end
                end
                default: ;
            endcase
        end
    end

    // Assemble indices, condition and trap flag for legal words only
    always_comb begin
        dec = '0;
        dec.cls = cls;
        dec.op  = op;
        if (cls == CL_NOP) begin
            dec.illegal = 1'b1;
        end else begin
            dec.frd      = {b28, n1};
            dec.frn      = {b29, n5};
            dec.frm      = {b30, n6};
            dec.core_idx = n2;
            dec.ctl_idx  = n1;
            dec.cond     = (cls == CL_CMP) ? n2 : '0;
            dec.may_trap = (cls != CL_MVF) && (cls != CL_MVC);
        end
    end
endmodule

// File: rtl/fpcop_outreg.sv
// Optional output stage. REG_OUT=1 registers the record with a synchronous
// active-low reset to all zeros; REG_OUT=0 passes it straight through.
module fpcop_outreg
    import fpcop_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  dec_t d_in,
    output dec_t d_out
);
    if (REG_OUT) begin : g_reg
        dec_t q;
        // Capture the decoded record each cycle
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d_in;
        end
        assign d_out = q;
    end else begin : g_comb
        assign d_out = d_in;
    end
endmodule

// File: rtl/fpcop_decoder.sv
// Top of the coprocessor instruction decoder: field split, pattern match
// and optional output register. Assumes bit 0 of the word is instr[31].
module fpcop_decoder
    import fpcop_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    output logic [CLS_W-1:0]   cls,
    output logic [OP_W-1:0]    op,
    output logic [FR_W-1:0]    frd,
    output logic [FR_W-1:0]    frn,
    output logic [FR_W-1:0]    frm,
    output logic [NIB_W-1:0]   core_idx,
    output logic [NIB_W-1:0]   ctl_idx,
    output logic [NIB_W-1:0]   cond,
    output logic               illegal,
    output logic               may_trap
);
    fields_t flds;
    dec_t    dec_c, dec_q;

    fpcop_fields   u_fields (.instr(instr), .flds(flds));
    fpcop_classify u_class  (.flds(flds), .dec(dec_c));
    fpcop_outreg #(.REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .d_in(dec_c), .d_out(dec_q)
    );

    assign cls      = dec_q.cls;
    assign op       = dec_q.op;
    assign frd      = dec_q.frd;
    assign frn      = dec_q.frn;
    assign frm      = dec_q.frm;
    assign core_idx = dec_q.core_idx;
    assign ctl_idx  = dec_q.ctl_idx;
    assign cond     = dec_q.cond;
    assign illegal  = dec_q.illegal;
    assign may_trap = dec_q.may_trap;
endmodule

// File: rtl/fpcop_decoder_chk.sv
// Property checker for fpcop_decoder, attached by bind below.
module fpcop_decoder_chk
    import fpcop_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic [CLS_W-1:0]   cls,
    input logic [OP_W-1:0]    op,
    input logic [FR_W-1:0]    frd,
    input logic [FR_W-1:0]    frn,
    input logic [FR_W-1:0]    frm,
    input logic [NIB_W-1:0]   core_idx,
    input logic [NIB_W-1:0]   ctl_idx,
    input logic [NIB_W-1:0]   cond,
    input logic               illegal,
    input logic               may_trap
);
    // R2: an illegal word leaves nothing behind on the outputs
    a_r2_illegal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (cls == '0 && op == '0 && frd == '0 && frn == '0 && frm == '0
                     && core_idx == '0 && ctl_idx == '0 && cond == '0 && !may_trap));

    // R10: trap flag only for arithmetic, conversion and compare classes
    a_r10_trap_classes: assert property (@(posedge clk) disable iff (!rst_n)
        may_trap |-> (cls >= 3'd1 && cls <= 3'd4));

    // R10: legal non-move words always carry the trap flag
    a_r10_nonmove_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (cls >= 3'd1 && cls <= 3'd4) |-> may_trap);

    // R7: compare words have zero destination and a condition only there
    a_r7_cmp_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd4) |-> (frd == '0 && ctl_idx == '0 && op == 5'd15));

    // R8: FP move opcodes stay in their pair
    a_r8_move_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == 3'd5) |-> (op == 5'd16 || op == 5'd17));

    // R1: a bad marker nibble always yields illegal
    if (REG_OUT) begin : g_seq
        a_r1_header: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(instr[31:28]) != 4'hF || $past(instr[19:16]) != 4'h7))
            |-> illegal);
    end else begin : g_comb
        a_r1_header: assert property (@(posedge clk) disable iff (!rst_n)
            (instr[31:28] != 4'hF || instr[19:16] != 4'h7) |-> illegal);
    end
endmodule

bind fpcop_decoder fpcop_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr), .cls(cls), .op(op),
    .frd(frd), .frn(frn), .frm(frm), .core_idx(core_idx), .ctl_idx(ctl_idx),
    .cond(cond), .illegal(illegal), .may_trap(may_trap)
);

// File: tb/fpcop_decoder_tb.sv
module fpcop_decoder_tb;
    typedef struct packed {
        logic [2:0] cls;
        logic [4:0] op;
        logic [4:0] frd;
        logic [4:0] frn;
        logic [4:0] frm;
        logic [3:0] core;
        logic [3:0] ctl;
        logic [3:0] cond;
        logic       ill;
        logic       trap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [2:0]  cls;
    logic [4:0]  op, frd, frn, frm;
    logic [3:0]  core_idx, ctl_idx, cond;
    logic        illegal, may_trap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    fpcop_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .cls(cls), .op(op),
        .frd(frd), .frn(frn), .frm(frm), .core_idx(core_idx), .ctl_idx(ctl_idx),
        .cond(cond), .illegal(illegal), .may_trap(may_trap)
    );

    function automatic exp_t actual();
        return '{cls, op, frd, frn, frm, core_idx, ctl_idx, cond, illegal, may_trap};
    endfunction

    // Word built from nibbles n0..n7, nibble 0 = bits 0..3 (MSB side)
    function automatic logic [31:0] mk(logic [3:0] n1, logic [3:0] n2, logic [3:0] n4,
                                      logic [3:0] n5, logic [3:0] n6, logic [3:0] n7);
        return {4'hF, n1, n2, 4'h7, n4, n5, n6, n7};
    endfunction

    function automatic exp_t e(int c, int o, int d, int n, int m, int cr, int ct,
                               int cd, int il, int tr);
        exp_t x;
        x = '{3'(c), 5'(o), 5'(d), 5'(n), 5'(m), 4'(cr), 4'(ct), 4'(cd), 1'(il), 1'(tr)};
        return x;
    endfunction

    localparam exp_t ILL = '{3'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b0};

    // Driver: present a word and queue its expected decode
    task automatic drive(logic [31:0] w, exp_t x, string tag);
        @(negedge clk);
        instr = w;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    // Monitor: one cycle after each word the registered outputs are compared
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t x;
                exp_t a;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                a = actual();
                n_chk++;
                if (a !== x) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", t, a, x);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset clears all outputs
        n_chk++;
        if (actual() !== exp_t'(0)) begin
            n_bad++;
            $display("FAIL R11 reset actual=%h expected=%h", actual(), exp_t'(0));
        end
        // R4 R3: add with all index high bits set
        drive(mk(4'h3, 4'h0, 4'h0, 4'h5, 4'h9, 4'b1110), e(1, 1, 19, 21, 25, 0, 3, 0, 0, 1), "R4 add");
        drive(mk(4'hA, 4'h3, 4'h0, 4'h0, 4'h0, 4'b0000), e(1, 4, 10, 0, 0, 3, 10, 0, 0, 1), "R4 div");
        drive(mk(4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'b0001), ILL, "R4 bit31 set");
        // R5 unary
        drive(mk(4'h2, 4'h4, 4'h0, 4'h7, 4'h0, 4'b1100), e(2, 5, 18, 23, 0, 4, 2, 0, 0, 1), "R5 sqrt");
        drive(mk(4'h0, 4'h7, 4'h0, 4'h0, 4'h0, 4'b0000), e(2, 8, 0, 0, 0, 7, 0, 0, 0, 1), "R5 negate");
        drive(mk(4'h0, 4'h6, 4'h0, 4'h0, 4'h1, 4'b0000), ILL, "R5 frm nibble set");
        drive(mk(4'h0, 4'h5, 4'h0, 4'h0, 4'h0, 4'b0010), ILL, "R5 bit30 set");
        // R6 conversions
        drive(mk(4'h0, 4'hE, 4'h0, 4'h0, 4'h0, 4'b0000), e(3, 11, 0, 0, 0, 14, 0, 0, 0, 1), "R6 ceil");
        drive(mk(4'h0, 4'h4, 4'h1, 4'h0, 4'h0, 4'b0000), e(3, 13, 0, 0, 0, 4, 0, 0, 0, 1), "R6 default");
        drive(mk(4'h1, 4'h0, 4'h9, 4'h2, 4'h0, 4'b0000), e(3, 14, 1, 2, 0, 0, 1, 0, 0, 1), "R6 int2float");
        drive(mk(4'h0, 4'h5, 4'h1, 4'h0, 4'h0, 4'b0000), ILL, "R6 bad sub");
        drive(mk(4'h0, 4'h9, 4'h0, 4'h0, 4'h0, 4'b0000), ILL, "R6 gap 8..B");
        // R7 compare
        drive(mk(4'h0, 4'hB, 4'h2, 4'h3, 4'h4, 4'b0110), e(4, 15, 0, 19, 20, 11, 0, 11, 0, 1), "R7 compare");
        drive(mk(4'h1, 4'hB, 4'h2, 4'h3, 4'h4, 4'b0000), ILL, "R7 frd nibble set");
        // R8 R10 FP moves
        drive(mk(4'h6, 4'h9, 4'hF, 4'h0, 4'h0, 4'b1000), e(5, 16, 22, 0, 0, 9, 6, 0, 0, 0), "R8 core to fp");
        drive(mk(4'h6, 4'h9, 4'hF, 4'h0, 4'h0, 4'b0001), e(5, 17, 6, 0, 0, 9, 6, 0, 0, 0), "R8 fp to core");
        drive(mk(4'h6, 4'h9, 4'hF, 4'h1, 4'h0, 4'b0000), ILL, "R8 frn nibble set");
        // R9 R10 control moves
        drive(mk(4'hF, 4'h2, 4'hF, 4'h0, 4'h0, 4'b0010), e(6, 18, 15, 0, 16, 2, 15, 0, 0, 0), "R9 core to ctl");
        drive(mk(4'h1, 4'h0, 4'hF, 4'h0, 4'h0, 4'b0011), e(6, 19, 1, 0, 16, 0, 1, 0, 0, 0), "R9 ctl to core");
        drive(mk(4'h1, 4'h0, 4'hF, 4'h0, 4'h0, 4'b1010), ILL, "R9 bit28 set");
        // R1 marker nibbles
        drive(32'hE3007000 | 32'h0, ILL, "R1 bad top nibble");
        drive(32'hF3006000, ILL, "R1 bad marker nibble");
        drive(mk(4'h0, 4'h2, 4'h0, 4'h0, 4'h0, 4'b0000), e(1, 3, 0, 0, 0, 2, 0, 0, 0, 1), "R2 recovers after illegal");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule